// File: doc/BRIEF.md
# Stored Image Revision Selector

This block decides which of four stored configuration images a flash read-out engine should stream. The images sit in a flash array cut into equal blocks, and each image uses a whole number of consecutive blocks. A two-bit revision number picks the image. The number comes either from two board-level select pins or from two internally programmed select bits. A source pin chooses between the two.

The choice is not a live multiplexer. It is captured once after power-on reset and then recaptured only on a small set of events:

- a rising edge of the chip-enable pin;
- a falling edge of the output-enable/reset pin while chip enable is low;
- a rising edge of the reconfigure pin while chip enable is low;
- a one-cycle reconfigure strobe from the JTAG logic.

Between these events the captured revision holds. Asynchronous pins pass through a synchronizer before any edge is looked for.

The captured revision indexes a table, supplied on configuration inputs, that gives each image's first block and block count. From this entry the block outputs the first and last word address of the image. A one-cycle pulse marks every recapture, so that a reader can restart at the new start address.

Top module: `rev_select_ctrl`

## Requirements
- R1: Revision codes are two bits: 00 is image 0, 01 image 1, 10 image 2 and 11 image 3. Entry k of each table occupies bits [k*BLK_W +: BLK_W]. `start_addr` equals the latched entry's first block times BLOCK_WORDS. `end_addr` equals (first block + block count) times BLOCK_WORDS minus one.
- R2: At capture, the revision comes from `ext_sel` when `sel_src_int` is 0 and from `int_sel` when it is 1.
- R3: While `rst_n` is low, `rev_q` is 00 and `rev_upd` is 0. After release, exactly one capture happens on its own, on the fourth rising clock edge after release (with two synchronizer stages).
- R4: A rising edge on `ce_pin` causes a capture. With two synchronizer stages, `rev_q` and `rev_upd` change on the third clock edge after the pin changes.
- R5: A falling edge on `oe_rst_pin` causes a capture when the synchronized `ce_pin` is low, and is ignored when it is high.
- R6: A rising edge on `reconf_pin` causes a capture when the synchronized `ce_pin` is low, and is ignored when it is high.
- R7: A high level on the synchronous `jtag_reconf` input causes a capture on the same clock edge.
- R8: Changing `ext_sel`, `int_sel` or `sel_src_int` alone never changes `rev_q`. Apart from the power-up capture, `rev_q` changes only at one of the events in R4 to R7.
- R9: `rev_upd` is high for exactly the cycle after each capture, even when the captured value equals the old one, and is low otherwise.
- R10: A block count of 0 in the table is treated as one block.
- R11: A falling edge of `ce_pin`, a rising edge of `oe_rst_pin` and a falling edge of `reconf_pin` cause no capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_sel | input | 2 | Board-level revision select pins (asynchronous) |
| int_sel | input | 2 | Internally programmed revision select bits |
| sel_src_int | input | 1 | 0: use `ext_sel`, 1: use `int_sel` (asynchronous) |
| ce_pin | input | 1 | Chip-enable pin level, low means enabled (asynchronous) |
| oe_rst_pin | input | 1 | Output-enable/reset pin level (asynchronous) |
| reconf_pin | input | 1 | Reconfigure request pin level (asynchronous) |
| jtag_reconf | input | 1 | JTAG reconfigure strobe, synchronous to `clk` |
| tbl_first_blk | input | 4*BLK_W | First block of each image, entry k at [k*BLK_W +: BLK_W] |
| tbl_blk_cnt | input | 4*BLK_W | Block count of each image, same packing |
| rev_q | output | 2 | Latched revision number |
| rev_upd | output | 1 | One-cycle pulse after each capture |
| start_addr | output | BLK_W+1+log2(BLOCK_WORDS) | First word address of the latched image |
| end_addr | output | BLK_W+1+log2(BLOCK_WORDS) | Last word address of the latched image |

## Verification
The capture logic is driven with single-pin transitions in both directions, each made with chip enable high and with it low. This separates qualified edges from ignored ones and from edges of the wrong polarity. Select values are also changed with no pin activity, which shows that the register holds rather than following its inputs. The source pin is toggled between captures, which shows which select pair was read at the edge. Random image tables, including zero counts and blocks at the top of the range, check the address arithmetic for every revision the captures land on.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   localparam int REV_W   = 2;
   localparam int NUM_REV = 4;
   typedef logic [REV_W-1:0] rev_t;
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rsc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/rsc_edge_events.sv
module rsc_edge_events (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ce_lvl,
   input  logic oe_lvl,
   input  logic rc_lvl,
   input  logic jtag_stb,
   output logic evt
);
   logic ce_prev, oe_prev, rc_prev;
   logic ce_rise, oe_fall, rc_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_prev <= 1'b0;
         oe_prev <= 1'b0;
         rc_prev <= 1'b0;
      end else begin
         ce_prev <= ce_lvl;
         oe_prev <= oe_lvl;
         rc_prev <= rc_lvl;
      end
   end

   // chip-enable low (active) qualifies the two gated edges
   assign ce_rise = ce_lvl & ~ce_prev;
   assign oe_fall = ~oe_lvl & oe_prev & ~ce_lvl;
   assign rc_rise = rc_lvl & ~rc_prev & ~ce_lvl;
   assign evt     = en & (ce_rise | oe_fall | rc_rise | jtag_stb);

   // R11: a lone chip-enable fall with other pins quiet must not trigger
   assert_ce_fall_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ce_lvl) && !ce_lvl && $stable(oe_lvl) && $stable(rc_lvl) && !jtag_stb) |-> !evt);

   // R5: an output-enable fall while chip enable stays high is ignored
   assert_oe_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(oe_lvl) && !oe_lvl && $past(ce_lvl) && ce_lvl && $stable(rc_lvl) && !jtag_stb) |-> !evt);
endmodule

// File: rtl/rsc_range_lut.sv
module rsc_range_lut
   import rsc_pkg::*;
#(
   parameter int BLK_W   = 8,
   parameter int OFS_W   = 19,
   parameter bit REG_OUT = 1'b0,
   localparam int ADDR_W = BLK_W + 1 + OFS_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  rev_t                     rev,
   input  logic [NUM_REV*BLK_W-1:0] first_blk,
   input  logic [NUM_REV*BLK_W-1:0] blk_cnt,
   output logic [ADDR_W-1:0]        start_addr,
   output logic [ADDR_W-1:0]        end_addr
);
   if (OFS_W < 1) begin : g_bad_ofs
      $error("rsc_range_lut: OFS_W must be at least 1");
   end

   logic [ADDR_W-1:0] ent_start [NUM_REV];
   logic [ADDR_W-1:0] ent_end   [NUM_REV];

   for (genvar k = 0; k < NUM_REV; k++) begin : g_ent
      logic [BLK_W-1:0] fb, cnt, cnt_eff;
      logic [BLK_W:0]   last_blk;
      assign fb       = first_blk[k*BLK_W +: BLK_W];
      assign cnt      = blk_cnt[k*BLK_W +: BLK_W];
      assign cnt_eff  = (cnt == '0) ? BLK_W'(1) : cnt;
      assign last_blk = {1'b0, fb} + {1'b0, cnt_eff} - (BLK_W+1)'(1);
      assign ent_start[k] = {1'b0, fb, {OFS_W{1'b0}}};
      assign ent_end[k]   = {last_blk, {OFS_W{1'b1}}};
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            start_addr <= '0;
            end_addr   <= {{(BLK_W+1){1'b0}}, {OFS_W{1'b1}}};
         end else begin
            start_addr <= ent_start[rev];
            end_addr   <= ent_end[rev];
         end
      end
   end else begin : g_comb
      assign start_addr = ent_start[rev];
      assign end_addr   = ent_end[rev];
   end

   // R1: an image never ends before it starts
   assert_range_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
      end_addr >= start_addr);

   // R10: the last word always closes a whole block
   assert_block_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
      &end_addr[OFS_W-1:0]);
endmodule

// File: rtl/rev_select_ctrl.sv
module rev_select_ctrl
   import rsc_pkg::*;
#(
   parameter int BLK_W       = 8,
   parameter int BLOCK_WORDS = 524288,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_RANGE   = 1'b0,
   localparam int OFS_W      = $clog2(BLOCK_WORDS),
   localparam int ADDR_W     = BLK_W + 1 + OFS_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [REV_W-1:0]         ext_sel,
   input  logic [REV_W-1:0]         int_sel,
   input  logic                     sel_src_int,
   input  logic                     ce_pin,
   input  logic                     oe_rst_pin,
   input  logic                     reconf_pin,
   input  logic                     jtag_reconf,
   input  logic [NUM_REV*BLK_W-1:0] tbl_first_blk,
   input  logic [NUM_REV*BLK_W-1:0] tbl_blk_cnt,
   output logic [REV_W-1:0]         rev_q,
   output logic                     rev_upd,
   output logic [ADDR_W-1:0]        start_addr,
   output logic [ADDR_W-1:0]        end_addr
);
   localparam int RAW_W    = 2*REV_W + 4;
   localparam int POR_LAST = SYNC_STAGES + 1;
   localparam int POR_CW   = $clog2(POR_LAST + 1);

   if (BLOCK_WORDS < 2 || (BLOCK_WORDS & (BLOCK_WORDS - 1)) != 0) begin : g_bad_bw
      $error("rev_select_ctrl: BLOCK_WORDS must be a power of two >= 2");
   end
   if (BLK_W < 1) begin : g_bad_blk
      $error("rev_select_ctrl: BLK_W must be at least 1");
   end

   logic [RAW_W-1:0] raw_in, sync_out;
   rev_t             ext_s, int_s, sel_now;
   logic             src_s, ce_s, oe_s, rc_s;
   logic [POR_CW-1:0] por_cnt;
   logic             por_done, por_fire, evt, load;

   assign raw_in = {ext_sel, int_sel, sel_src_int, ce_pin, oe_rst_pin, reconf_pin};

   rsc_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
   );

   assign {ext_s, int_s, src_s, ce_s, oe_s, rc_s} = sync_out;

   // power-up capture waits until the synchronizer and edge history are valid
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         por_cnt  <= '0;
         por_done <= 1'b0;
      end else if (!por_done) begin
         if (por_cnt == POR_CW'(POR_LAST)) por_done <= 1'b1;
         else                              por_cnt  <= por_cnt + 1'b1;
      end
   end

   assign por_fire = !por_done && (por_cnt == POR_CW'(POR_LAST));

   rsc_edge_events u_evt (
      .clk(clk), .rst_n(rst_n), .en(por_done),
      .ce_lvl(ce_s), .oe_lvl(oe_s), .rc_lvl(rc_s),
      .jtag_stb(jtag_reconf), .evt(evt)
   );

   assign sel_now = src_s ? int_s : ext_s;
   assign load    = por_fire | evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rev_q   <= '0;
         rev_upd <= 1'b0;
      end else begin
         if (load) rev_q <= sel_now;
         rev_upd <= load;
      end
   end

   rsc_range_lut #(.BLK_W(BLK_W), .OFS_W(OFS_W), .REG_OUT(REG_RANGE)) u_lut (
      .clk(clk), .rst_n(rst_n), .rev(rev_q),
      .first_blk(tbl_first_blk), .blk_cnt(tbl_blk_cnt),
      .start_addr(start_addr), .end_addr(end_addr)
   );

   // R8: the latched revision moves only together with an update pulse
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rev_upd |-> $stable(rev_q));

   // R3: no update pulse before the power-up capture has completed
   assert_upd_after_por_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rev_upd |-> por_done);

   // R3: the power-up capture happens once
   assert_por_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
      por_done |=> por_done);
endmodule

// File: tb/tb_rev_select_ctrl.sv
`timescale 1ns/1ps
module tb_rev_select_ctrl;
   localparam int BLK_W = 8;
   localparam int BW    = 524288;
   localparam int AW    = BLK_W + 1 + $clog2(BW);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] ext_sel = 2'd2, int_sel = 2'd1;
   logic sel_src_int = 1'b0, ce_pin = 1'b1, oe_rst_pin = 1'b1, reconf_pin = 1'b0;
   logic jtag_reconf = 1'b0;
   logic [4*BLK_W-1:0] tbl_first_blk, tbl_blk_cnt;
   logic [1:0] rev_q;
   logic rev_upd;
   logic [AW-1:0] start_addr, end_addr;

   int tests = 0, fails = 0;
   int model_rev = 0;
   int st_tab [4];
   int cn_tab [4];

   always #2.5 clk = ~clk;

   rev_select_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .int_sel(int_sel),
      .sel_src_int(sel_src_int), .ce_pin(ce_pin), .oe_rst_pin(oe_rst_pin),
      .reconf_pin(reconf_pin), .jtag_reconf(jtag_reconf),
      .tbl_first_blk(tbl_first_blk), .tbl_blk_cnt(tbl_blk_cnt),
      .rev_q(rev_q), .rev_upd(rev_upd), .start_addr(start_addr), .end_addr(end_addr)
   );

   task automatic chk(bit ok, string tag, longint act, longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint exp_start(int r);
      return longint'(st_tab[r]) * BW;
   endfunction

   function automatic longint exp_end(int r);
      int c = (cn_tab[r] == 0) ? 1 : cn_tab[r];
      return (longint'(st_tab[r]) + c) * BW - 1;
   endfunction

   function automatic int sel_model();
      return sel_src_int ? int'(int_sel) : int'(ext_sel);
   endfunction

   task automatic load_table();
      for (int k = 0; k < 4; k++) begin
         st_tab[k] = $urandom % 256;
         cn_tab[k] = $urandom % 256;
         tbl_first_blk[k*BLK_W +: BLK_W] = BLK_W'(st_tab[k]);
         tbl_blk_cnt[k*BLK_W +: BLK_W]   = BLK_W'(cn_tab[k]);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_range();
      string t = (cn_tab[model_rev] == 0) ? "R10" : "R1";
      chk(longint'(start_addr) == exp_start(model_rev), t, longint'(start_addr), exp_start(model_rev));
      chk(longint'(end_addr) == exp_end(model_rev), t, longint'(end_addr), exp_end(model_rev));
   endtask

   task automatic set_sel(logic [1:0] e, logic [1:0] i, logic s);
      bit quiet = 1'b1;
      ext_sel = e; int_sel = i; sel_src_int = s;
      for (int n = 0; n < 4; n++) begin
         cyc();
         if (rev_upd) quiet = 1'b0;
      end
      chk(quiet, "R8", longint'(!quiet), 0);
      chk(rev_q == model_rev[1:0], "R8", rev_q, model_rev);
   endtask

   // which: 0 chip enable, 1 output-enable/reset, 2 reconfigure
   task automatic set_pin(int which, logic val);
      bit ev = 1'b0;
      string tag = "R8";
      if (which == 0) begin
         if (val != ce_pin) begin
            ev = val; tag = val ? "R4" : "R11";
         end
         ce_pin = val;
      end else if (which == 1) begin
         if (val != oe_rst_pin) begin
            ev = !val && !ce_pin; tag = val ? "R11" : "R5";
         end
         oe_rst_pin = val;
      end else begin
         if (val != reconf_pin) begin
            ev = val && !ce_pin; tag = val ? "R6" : "R11";
         end
         reconf_pin = val;
      end
      cyc(); cyc();
      chk(rev_upd == 1'b0, tag, rev_upd, 0);
      cyc();
      chk(rev_upd == ev, tag, rev_upd, ev);
      if (ev) model_rev = sel_model();
      chk(rev_q == model_rev[1:0], tag, rev_q, model_rev);
      check_range();
      cyc();
      chk(rev_upd == 1'b0, "R9", rev_upd, 0);
   endtask

   task automatic jtag_pulse();
      jtag_reconf = 1'b1;
      cyc();
      jtag_reconf = 1'b0;
      chk(rev_upd == 1'b1, "R7", rev_upd, 1);
      model_rev = sel_model();
      chk(rev_q == model_rev[1:0], sel_src_int ? "R2" : "R7", rev_q, model_rev);
      check_range();
      cyc();
      chk(rev_upd == 1'b0, "R9", rev_upd, 0);
   endtask

   initial begin
      int pulses = 0;
      void'($urandom(32'd4711));
      load_table();
      cn_tab[2] = 0; tbl_blk_cnt[2*BLK_W +: BLK_W] = '0;
      st_tab[3] = 255; tbl_first_blk[3*BLK_W +: BLK_W] = 8'd255;
      cn_tab[3] = 255; tbl_blk_cnt[3*BLK_W +: BLK_W] = 8'd255;
      repeat (3) @(negedge clk);
      chk(rev_q == 2'd0, "R3", rev_q, 0);
      chk(rev_upd == 1'b0, "R3", rev_upd, 0);
      rst_n = 1'b1;
      for (int n = 0; n < 10; n++) begin
         cyc();
         if (rev_upd) pulses++;
         if (n == 3) chk(rev_upd == 1'b1, "R3", rev_upd, 1);
      end
      chk(pulses == 1, "R3", pulses, 1);
      model_rev = 2;
      chk(rev_q == 2'd2, "R3", rev_q, 2);
      check_range();

      set_sel(2'd1, 2'd3, 1'b0);
      set_pin(0, 1'b0);          // R11 chip enable fall
      set_pin(0, 1'b1);          // R4 -> revision 1
      set_sel(2'd0, 2'd3, 1'b1); // R2 internal bits
      set_pin(1, 1'b0);          // R5 ignored, chip enable high
      set_pin(1, 1'b1);          // R11
      set_pin(0, 1'b0);
      set_pin(1, 1'b0);          // R5 -> revision 3, top of the array
      set_sel(2'd2, 2'd0, 1'b0);
      set_pin(2, 1'b1);          // R6 -> revision 2, R10 zero count
      set_pin(2, 1'b0);          // R11
      set_pin(0, 1'b1);          // R4 with same revision, R9 still pulses
      set_pin(2, 1'b1);          // R6 ignored, chip enable high
      set_sel(2'd3, 2'd0, 1'b1);
      jtag_pulse();              // R7 + R2 -> revision 0
      load_table();
      cyc();
      check_range();

      for (int it = 0; it < 250; it++) begin
         int k = $urandom % 5;
         if (k == 0) set_sel(2'($urandom), 2'($urandom), 1'($urandom));
         else if (k == 4) jtag_pulse();
         else if (k == 1) set_pin(0, !ce_pin);
         else if (k == 2) set_pin(1, !oe_rst_pin);
         else set_pin(2, !reconf_pin);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule